// File: doc/BRIEF.md
# Dispatch Admission Controller

This block sits between decode and the out-of-order back end. Each clock it looks at the one instruction that decode presents and decides whether that instruction may enter the back end now. It keeps a per-group dispatch budget of `WIDTH` micro-op entries. A dispatch group starts whenever `grp_start_i` is high, and the budget is refilled at that point. The controller also weighs three resource verdicts that arrive from outside: a per-register-file rename stall mask, a retire-queue space flag and a scheduler status code. The resources themselves live elsewhere.

An instruction whose micro-op count exceeds `WIDTH` may enter only into an untouched group. It takes the whole group, and the micro-ops it has left over are held as carry-over. While any carry-over remains, nothing new is admitted. Each later group start pays the carry-over down by `WIDTH` and refills the budget with whatever is left.

When the bandwidth allows an instruction but a resource refuses it, the controller raises a stall event. The event carries the instruction id and a 3-bit cause. On a successful dispatch, the controller tells the retire queue how many slots to reserve. All results are registered and appear one clock after the instruction is presented.

Top module: `disp_admit`

## Requirements
- R1: After reset, `disp_o`, `stall_o` and `busy_o` are low and the budget is full, so an instruction of `WIDTH` micro-ops is admitted without a group start.
- R2: An instruction with micro-op count not above `WIDTH` and not above the remaining budget, with all resources ready, is dispatched. Its count is taken from the budget. A count of zero is dispatched and uses no budget.
- R3: An instruction with count not above `WIDTH` but above the remaining budget is neither dispatched nor stalled, and the budget stays as it was.
- R4: An instruction with count above `WIDTH` is admitted only while the budget is exactly `WIDTH`. It then empties the budget, sets the carry-over to count minus `WIDTH` and drives `busy_o` high while the carry-over is nonzero.
- R5: At a group start the budget becomes `WIDTH` minus the carry-over, with a floor of 0. The carry-over drops by `WIDTH`, with a floor of 0. Both changes apply before the instruction presented in the same cycle is judged.
- R6: While the carry-over is nonzero, no instruction is dispatched and no stall event is raised.
- R7: A nonzero rename stall mask gives stall cause 1, whatever the other verdicts are.
- R8: With a clear rename mask and `rq_ok_i` low, the stall cause is 2.
- R9: With the rename and retire checks clear, the scheduler status decides. Status 0 dispatches. Status 1, 2, 3 and 4 stall with causes 3, 4, 5 and 6. Status 5 to 7 stall with cause 3.
- R10: A stalled instruction uses no budget. At most one of `disp_o` and `stall_o` is high in a cycle, and `evt_id_o` carries the id of the instruction concerned.
- R11: On a dispatch, `disp_slots_o` is the micro-op count, or 1 when the count is zero.
- R12: Results are registered one cycle after the inputs. A cycle with `inst_vld_i` low produces neither a dispatch nor a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_start_i | input | 1 | A new dispatch group begins this cycle |
| inst_vld_i | input | 1 | An instruction is presented |
| inst_id_i | input | ID_W | Id of the presented instruction |
| inst_uops_i | input | UOP_W | Micro-op count of the presented instruction |
| rf_stall_i | input | NRF | Per-register-file rename shortage mask |
| rq_ok_i | input | 1 | Retire queue has room for the instruction |
| sched_st_i | input | 3 | Scheduler status code |
| disp_o | output | 1 | Instruction dispatched |
| disp_slots_o | output | UOP_W | Retire slots to reserve for the dispatch |
| stall_o | output | 1 | Stall event |
| stall_cause_o | output | 3 | Stall cause code |
| evt_id_o | output | ID_W | Id of the dispatched or stalled instruction |
| busy_o | output | 1 | Carry-over pending |

## Verification
Every output is registered, so the results for inputs presented in cycle N are due in cycle N+1. This includes the dispatch strobe, the slot count, the stall event with its cause and id, and the busy flag after a carry-over change. The driver tags each expected item with the cycle in which its inputs were applied. The monitor compares an item only once the counter has moved past that cycle, and it samples midway between edges. A budget or carry-over change cannot be seen directly, so it is judged through the admission or refusal of the next instruction.

// File: rtl/disp_admit_pkg.sv
package disp_admit_pkg;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_RENAME  = 3'd1,
      CAUSE_RETIRE  = 3'd2,
      CAUSE_SQ_FULL = 3'd3,
      CAUSE_LD_FULL = 3'd4,
      CAUSE_ST_FULL = 3'd5,
      CAUSE_GROUP   = 3'd6
   } cause_e;

   typedef enum logic [2:0] {
      SCH_READY   = 3'd0,
      SCH_Q_FULL  = 3'd1,
      SCH_LD_FULL = 3'd2,
      SCH_ST_FULL = 3'd3,
      SCH_GROUP   = 3'd4
   } sched_st_e;

   function automatic cause_e sched_cause(input logic [2:0] st);
      case (st)
         SCH_READY:   return CAUSE_NONE;
         SCH_Q_FULL:  return CAUSE_SQ_FULL;
         SCH_LD_FULL: return CAUSE_LD_FULL;
         SCH_ST_FULL: return CAUSE_ST_FULL;
         SCH_GROUP:   return CAUSE_GROUP;
         default:     return CAUSE_SQ_FULL;
      endcase
   endfunction

endpackage

// File: rtl/disp_admit_budget.sv
module disp_admit_budget #(
   parameter int WIDTH = 4,
   parameter int UOP_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             grp_start_i,
   input  logic [UOP_W-1:0] uops_i,
   input  logic             take_i,
   output logic             bw_ok_o,
   output logic             busy_o
);
   localparam logic [UOP_W-1:0] W_U = UOP_W'(WIDTH);

   logic [UOP_W-1:0] avail_q, carry_q;
   logic [UOP_W-1:0] avail_eff, carry_eff;
   logic             oversize;

   // group start refill happens before judging this cycle's instruction
   always_comb begin
      if (grp_start_i) begin
         avail_eff = (carry_q >= W_U) ? '0 : W_U - carry_q;
         carry_eff = (carry_q > W_U) ? carry_q - W_U : '0;
      end else begin
         avail_eff = avail_q;
         carry_eff = carry_q;
      end
   end

   assign oversize = uops_i > W_U;
   assign bw_ok_o  = (carry_eff == '0) &&
                     (oversize ? (avail_eff == W_U) : (uops_i <= avail_eff));
   assign busy_o   = carry_q != '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         avail_q <= W_U;
         carry_q <= '0;
      end else if (take_i && oversize) begin
         avail_q <= '0;
         carry_q <= uops_i - W_U;
      end else if (take_i) begin
         avail_q <= avail_eff - uops_i;
         carry_q <= carry_eff;
      end else begin
         avail_q <= avail_eff;
         carry_q <= carry_eff;
      end
   end
endmodule

// File: rtl/disp_admit_cause.sv
module disp_admit_cause
   import disp_admit_pkg::*;
#(
   parameter int NRF = 2
) (
   input  logic [NRF-1:0] rf_stall_i,
   input  logic           rq_ok_i,
   input  logic [2:0]     sched_st_i,
   output cause_e         cause_o
);
   logic rf_block;

   generate
      if (NRF == 1) begin : g_single_rf
         assign rf_block = rf_stall_i[0];
      end else begin : g_multi_rf
         assign rf_block = |rf_stall_i;
      end
   endgenerate

   // fixed priority: rename, then retire queue, then scheduler
   always_comb begin
      if (rf_block)      cause_o = CAUSE_RENAME;
      else if (!rq_ok_i) cause_o = CAUSE_RETIRE;
      else               cause_o = sched_cause(sched_st_i);
   end
endmodule

// File: rtl/disp_admit.sv
module disp_admit
   import disp_admit_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int UOP_W = 4,
   parameter int ID_W  = 6,
   parameter int NRF   = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             grp_start_i,
   input  logic             inst_vld_i,
   input  logic [ID_W-1:0]  inst_id_i,
   input  logic [UOP_W-1:0] inst_uops_i,
   input  logic [NRF-1:0]   rf_stall_i,
   input  logic             rq_ok_i,
   input  logic [2:0]       sched_st_i,
   output logic             disp_o,
   output logic [UOP_W-1:0] disp_slots_o,
   output logic             stall_o,
   output logic [2:0]       stall_cause_o,
   output logic [ID_W-1:0]  evt_id_o,
   output logic             busy_o
);
   localparam int MAX_UOPS = (1 << UOP_W) - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("disp_admit: WIDTH must be at least 1");
      end
      if (MAX_UOPS < WIDTH) begin : g_bad_uop_w
         $error("disp_admit: UOP_W too narrow to hold WIDTH");
      end
      if (NRF < 1) begin : g_bad_nrf
         $error("disp_admit: NRF must be at least 1");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("disp_admit: ID_W must be at least 1");
      end
   endgenerate

   logic   bw_ok, take, refuse;
   cause_e cause;

   disp_admit_cause #(.NRF(NRF)) u_cause (
      .rf_stall_i (rf_stall_i),
      .rq_ok_i    (rq_ok_i),
      .sched_st_i (sched_st_i),
      .cause_o    (cause)
   );

   assign take   = inst_vld_i && bw_ok && (cause == CAUSE_NONE);
   assign refuse = inst_vld_i && bw_ok && (cause != CAUSE_NONE);

   disp_admit_budget #(.WIDTH(WIDTH), .UOP_W(UOP_W)) u_budget (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .grp_start_i (grp_start_i),
      .uops_i      (inst_uops_i),
      .take_i      (take),
      .bw_ok_o     (bw_ok),
      .busy_o      (busy_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         disp_o        <= 1'b0;
         disp_slots_o  <= '0;
         stall_o       <= 1'b0;
         stall_cause_o <= 3'd0;
         evt_id_o      <= '0;
      end else begin
         disp_o        <= take;
         disp_slots_o  <= (inst_uops_i == '0) ? UOP_W'(1) : inst_uops_i;
         stall_o       <= refuse;
         stall_cause_o <= refuse ? 3'(cause) : 3'd0;
         evt_id_o      <= inst_id_i;
      end
   end
endmodule

// File: rtl/disp_admit_chk.sv
module disp_admit_chk #(
   parameter int UOP_W = 4,
   parameter int ID_W  = 6,
   parameter int NRF   = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             grp_start_i,
   input logic             inst_vld_i,
   input logic [UOP_W-1:0] inst_uops_i,
   input logic [NRF-1:0]   rf_stall_i,
   input logic             rq_ok_i,
   input logic             disp_o,
   input logic [UOP_W-1:0] disp_slots_o,
   input logic             stall_o,
   input logic [2:0]       stall_cause_o,
   input logic             busy_o
);
   assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(disp_o && stall_o));

   assert_rename_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_o && ($past(rf_stall_i) != '0)) |-> (stall_cause_o == 3'd1));

   assert_retire_second_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_o && ($past(rf_stall_i) == '0) && !$past(rq_ok_i)) |-> (stall_cause_o == 3'd2));

   assert_slots_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_o |-> (disp_slots_o == (($past(inst_uops_i) == '0) ? UOP_W'(1) : $past(inst_uops_i))));

   assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !grp_start_i) |=> (!disp_o && !stall_o));

   assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !inst_vld_i |=> (!disp_o && !stall_o));
endmodule

bind disp_admit disp_admit_chk #(.UOP_W(UOP_W), .ID_W(ID_W), .NRF(NRF)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .grp_start_i   (grp_start_i),
   .inst_vld_i    (inst_vld_i),
   .inst_uops_i   (inst_uops_i),
   .rf_stall_i    (rf_stall_i),
   .rq_ok_i       (rq_ok_i),
   .disp_o        (disp_o),
   .disp_slots_o  (disp_slots_o),
   .stall_o       (stall_o),
   .stall_cause_o (stall_cause_o),
   .busy_o        (busy_o)
);

// File: tb/disp_admit_tb.sv
module disp_admit_tb;
   localparam int W     = 4;
   localparam int UOP_W = 4;
   localparam int ID_W  = 6;
   localparam int NRF   = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             grp = 1'b0, vld = 1'b0, rq_ok = 1'b1;
   logic [ID_W-1:0]  id = '0;
   logic [UOP_W-1:0] uops = '0;
   logic [NRF-1:0]   rfm = '0;
   logic [2:0]       sts = '0;
   logic             disp, stall, busy;
   logic [UOP_W-1:0] slots;
   logic [2:0]       cause;
   logic [ID_W-1:0]  eid;

   always #2 clk = ~clk;

   disp_admit #(.WIDTH(W), .UOP_W(UOP_W), .ID_W(ID_W), .NRF(NRF)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .grp_start_i(grp), .inst_vld_i(vld),
      .inst_id_i(id), .inst_uops_i(uops), .rf_stall_i(rfm), .rq_ok_i(rq_ok),
      .sched_st_i(sts), .disp_o(disp), .disp_slots_o(slots), .stall_o(stall),
      .stall_cause_o(cause), .evt_id_o(eid), .busy_o(busy)
   );

   typedef struct {
      int    stamp;
      bit    d;
      int    sl;
      bit    s;
      int    c;
      int    id;
      bit    b;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0, checks = 0, errors = 0;
   int   m_avail = W, m_carry = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic step(input bit v, input bit g, input int u, input int iid,
                       input int rf, input bit rq, input int st, input string tag);
      exp_t e;
      int ea, ec, cs;
      bit bw;
      @(posedge clk); #1;
      vld = v; grp = g; uops = UOP_W'(u); id = ID_W'(iid);
      rfm = NRF'(rf); rq_ok = rq; sts = 3'(st);
      ea = g ? ((m_carry >= W) ? 0 : W - m_carry) : m_avail;
      ec = g ? ((m_carry > W) ? m_carry - W : 0) : m_carry;
      e.d = 0; e.s = 0; e.c = 0; e.id = iid; e.tag = tag;
      e.sl = (u == 0) ? 1 : u;
      if (v && ec == 0) begin
         bw = (u > W) ? (ea == W) : (u <= ea);
         if (bw) begin
            cs = (rf != 0) ? 1 : (!rq) ? 2 : (st == 0) ? 0 : (st <= 4) ? st + 2 : 3;
            if (cs == 0) begin
               e.d = 1;
               if (u > W) begin ea = 0; ec = u - W; end
               else ea = ea - u;
            end else begin
               e.s = 1; e.c = cs;
            end
         end
      end
      m_avail = ea; m_carry = ec;
      e.b = (m_carry != 0);
      e.stamp = cyc;
      q.push_back(e);
   endtask

   // monitor: compares each item once the edge after its inputs has passed
   initial begin
      forever begin
         exp_t e;
         bit bad;
         @(posedge clk); #2;
         while (q.size() > 0 && q[0].stamp < cyc) begin
            e = q.pop_front();
            bad = (disp !== e.d) || (stall !== e.s) || (busy !== e.b) ||
                  (e.d && (int'(slots) != e.sl)) || (e.s && (int'(cause) != e.c)) ||
                  ((e.d || e.s) && (int'(eid) != e.id));
            checks++;
            if (bad) begin
               errors++;
               $display("FAIL %s: act disp=%0d slots=%0d stall=%0d cause=%0d id=%0d busy=%0d exp disp=%0d slots=%0d stall=%0d cause=%0d id=%0d busy=%0d",
                        e.tag, disp, slots, stall, cause, eid, busy,
                        e.d, e.sl, e.s, e.c, e.id, e.b);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: act hung exp finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      checks++;
      if (disp !== 1'b0 || stall !== 1'b0 || busy !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: act disp=%0d stall=%0d busy=%0d exp 0 0 0", disp, stall, busy);
      end
      // R1: full budget straight out of reset
      step(1, 0, 4, 1, 0, 1, 0, "R1 full budget");
      // R2 / R3 / R5
      step(1, 1, 2, 2, 0, 1, 0, "R2 fits");
      step(1, 0, 2, 3, 0, 1, 0, "R2 fits exactly");
      step(1, 0, 1, 4, 0, 1, 0, "R3 over budget");
      step(1, 0, 0, 5, 0, 1, 0, "R2 R11 zero uops");
      step(1, 1, 1, 6, 0, 1, 0, "R5 refill");
      step(1, 0, 4, 7, 0, 1, 0, "R3 too wide for rest");
      // R3 with a resource refusal: no stall because bandwidth fails first
      step(1, 0, 4, 8, 1, 0, 1, "R3 bw before rename");
      // R4 oversize needs untouched group
      step(1, 1, 1, 9, 0, 1, 0, "R2 partial group");
      step(1, 0, 6, 10, 0, 1, 0, "R4 blocked partial");
      step(1, 1, 6, 11, 0, 1, 0, "R4 oversize admitted");
      step(1, 0, 1, 12, 0, 1, 0, "R6 carry holds");
      step(1, 0, 1, 13, 3, 0, 2, "R6 no stall while busy");
      step(1, 1, 2, 14, 0, 1, 0, "R5 carry paid, rest 2");
      step(1, 0, 1, 15, 0, 1, 0, "R3 rest used");
      // R4 large carry over several groups
      step(1, 1, 11, 16, 0, 1, 0, "R4 count 11");
      step(0, 1, 0, 0, 0, 1, 0, "R5 carry 7 to 3");
      step(1, 1, 1, 17, 0, 1, 0, "R5 carry 3 gone, rest 1");
      step(1, 0, 1, 18, 0, 1, 0, "R3 rest 0");
      // stall causes and priority
      step(1, 1, 1, 19, 2, 0, 3, "R7 rename first");
      step(1, 0, 1, 20, 0, 0, 4, "R8 retire second");
      step(1, 0, 1, 21, 0, 1, 1, "R9 sched queue");
      step(1, 0, 1, 22, 0, 1, 2, "R9 load queue");
      step(1, 0, 1, 23, 0, 1, 3, "R9 store queue");
      step(1, 0, 1, 24, 0, 1, 4, "R9 group rule");
      step(1, 0, 1, 25, 0, 1, 6, "R9 unknown code");
      // R10: stalls took no budget, whole width still there
      step(1, 0, 4, 26, 0, 1, 0, "R10 budget intact");
      step(0, 1, 3, 27, 1, 0, 1, "R12 idle");
      step(1, 0, 9, 28, 0, 1, 0, "R4 R11 oversize slots");
      step(0, 0, 0, 0, 0, 1, 0, "R12 idle busy");
      step(0, 1, 0, 0, 0, 1, 0, "drain");
      step(0, 0, 0, 0, 0, 1, 0, "drain");
      repeat (3) @(posedge clk);
      #3;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule